// File: doc/BRIEF.md
# System Register Bank

A 32-bit register bank that sits on a simple single-cycle bus-slave port. Each access is one cycle of `acc_stb` with an address, a write enable and write data. A write takes effect on the clock edge where the strobe is sampled. A read loads `acc_rdata` on that same edge, and the value stays there until the next read.

The bank holds several kinds of register:
- identification words, read-only and set by parameters;
- a switch input word and card-status input bits;
- an LED output register, a flash write-protect output bit (active low) and a master-site select bit;
- a free-running tick counter;
- two flag words, one volatile and one non-volatile.

Each flag word has a set alias and a clear alias. A write to the set alias ORs the data into the flags, and a read of the set alias returns the flags. A write to the clear alias removes every bit that is 1 in the data. The synchronous `soft_rst` input clears only the volatile flag word. The asynchronous `rst_n` clears everything.

The bank has no control sequencer. The only decision made per access is decode → select → update/capture, and it completes within the strobe cycle.

Top module: `sysreg_bank`

## Requirements
- R1: After `rst_n` is asserted, `led_o`, `flash_wp_n_o`, `master_sel_o` and `acc_rdata` are 0. Both flag words and the tick counter also read 0.
- R2: Offset 0x000 reads `{4'h0, ID_BOARD[11:0], ID_LOW[15:0]}`, so the board code is in bits 27:16. Offsets 0x084 and 0x088 read `PROC0_ID` and `PROC1_ID`, whose board code is in bits 11:0. Writes to these three offsets are ignored.
- R3: A write to offset 0x008 stores data bits 7:0. Stored bit n drives `led_o[n]`. A read returns the stored byte with the upper bits at zero.
- R4: A write to offset 0x030 ORs the data into the volatile flags. A read of 0x030 returns the volatile flags.
- R5: A write to offset 0x034 clears each volatile flag bit that is 1 in the data, so all ones clears the word. A read of 0x034 returns zero.
- R6: Offsets 0x038 (set and read) and 0x03C (clear) follow the same rules for the non-volatile flags. These accesses leave the volatile flags unchanged.
- R7: One cycle of `soft_rst` high clears the volatile flags. It leaves the non-volatile flags, the LED register and the other stored bits unchanged.
- R8: Offset 0x048 reads `card_present_i` in bit 0 and `card_wprot_i` in bit 1, with all other bits at zero. Writes to it are ignored.
- R9: Offset 0x04C bit 0 is writable and readable, and it drives `flash_wp_n_o`. A value of 0 means protected.
- R10: Offset 0x060 stores only bit 14, which drives `master_sel_o` (1 selects site 2, 0 selects site 1). All other bits read zero.
- R11: Offset 0x024 reads a counter that increments by one on each clock edge where `tick_en` is high. Writes to it are ignored.
- R12: The following read zero: undecoded offsets, offsets with `acc_addr[1:0]` not equal to 0, and the gap offsets. A cycle without `acc_stb` changes no register. `acc_rdata` changes only on a read access.
- R13: Offset 0x004 reads `sw_i`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of the volatile flags |
| acc_stb | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte address |
| acc_wdata | input | DATA_W (32) | Write data |
| acc_rdata | output | DATA_W (32) | Read data, captured on read accesses |
| tick_en | input | 1 | Counter tick enable |
| sw_i | input | SW_N (8) | Switch inputs |
| card_present_i | input | 1 | Card present input |
| card_wprot_i | input | 1 | Card write-protect input |
| led_o | output | LED_N (8) | LED drives |
| flash_wp_n_o | output | 1 | Flash write protect, active low |
| master_sel_o | output | 1 | Master site select |

## Verification
The assertions assume that every input is synchronous to `clk` and that a strobe cycle carries exactly one access. They make no assumption about how `soft_rst` lines up with bus accesses, since the flag logic gives soft reset priority over a set or a clear. The bench changes every input on the falling edge and keeps `acc_stb` high for exactly one cycle per access. It holds `tick_en` low while the table is walked, so the counter value it reads is known, and it raises `tick_en` only for a counted window.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam logic [11:0] OFS_ID     = 12'h000;
    localparam logic [11:0] OFS_SW     = 12'h004;
    localparam logic [11:0] OFS_LED    = 12'h008;
    localparam logic [11:0] OFS_TICK   = 12'h024;
    localparam logic [11:0] OFS_FSET   = 12'h030;
    localparam logic [11:0] OFS_FCLR   = 12'h034;
    localparam logic [11:0] OFS_NSET   = 12'h038;
    localparam logic [11:0] OFS_NCLR   = 12'h03C;
    localparam logic [11:0] OFS_CARD   = 12'h048;
    localparam logic [11:0] OFS_FLASH  = 12'h04C;
    localparam logic [11:0] OFS_MISC   = 12'h060;
    localparam logic [11:0] OFS_PROC0  = 12'h084;
    localparam logic [11:0] OFS_PROC1  = 12'h088;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_ID, SEL_SW, SEL_LED, SEL_TICK,
        SEL_FSET, SEL_FCLR, SEL_NSET, SEL_NCLR,
        SEL_CARD, SEL_FLASH, SEL_MISC, SEL_PROC0, SEL_PROC1
    } reg_sel_e;

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        unique case (addr)
            ADDR_W'(OFS_ID):    sel = SEL_ID;
            ADDR_W'(OFS_SW):    sel = SEL_SW;
            ADDR_W'(OFS_LED):   sel = SEL_LED;
            ADDR_W'(OFS_TICK):  sel = SEL_TICK;
            ADDR_W'(OFS_FSET):  sel = SEL_FSET;
            ADDR_W'(OFS_FCLR):  sel = SEL_FCLR;
            ADDR_W'(OFS_NSET):  sel = SEL_NSET;
            ADDR_W'(OFS_NCLR):  sel = SEL_NCLR;
            ADDR_W'(OFS_CARD):  sel = SEL_CARD;
            ADDR_W'(OFS_FLASH): sel = SEL_FLASH;
            ADDR_W'(OFS_MISC):  sel = SEL_MISC;
            ADDR_W'(OFS_PROC0): sel = SEL_PROC0;
            ADDR_W'(OFS_PROC1): sel = SEL_PROC1;
            default:            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysreg_flagword.sv
module sysreg_flagword #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (clr_all) q <= '0;
        else if (set_en)  q <= q | wdata;
        else if (clr_en)  q <= q & ~wdata;
    end

    // R7: soft reset empties the word on the next edge
    p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (q == '0));

    // R4: every written set bit is present afterwards
    p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> ((q & $past(wdata)) == $past(wdata)));

    // R5: every written clear bit is gone afterwards
    p_clear_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && !clr_all) |=> ((q & $past(wdata)) == '0));

    // R6: without a set, clear or soft reset the word holds
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en && !clr_all) |=> $stable(q));

endmodule

// File: rtl/sysreg_tick_ctr.sv
module sysreg_tick_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (tick_en) q <= q + 1'b1;
    end

    // R11: one step per tick, no step otherwise
    p_tick_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (q == $past(q) + 1'b1));

    p_tick_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(q));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter int          LED_N      = 8,
    parameter int          SW_N       = 8,
    parameter int          MASTER_BIT = 14,
    parameter logic [11:0] ID_BOARD   = 12'h190,
    parameter logic [15:0] ID_LOW     = 16'h0A05,
    parameter logic [31:0] PROC0_ID   = 32'h1400_0191,
    parameter logic [31:0] PROC1_ID   = 32'h2400_0192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              acc_stb,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              tick_en,
    input  logic [SW_N-1:0]   sw_i,
    input  logic              card_present_i,
    input  logic              card_wprot_i,
    output logic [LED_N-1:0]  led_o,
    output logic              flash_wp_n_o,
    output logic              master_sel_o
);

    localparam logic [31:0] ID_WORD = {4'h0, ID_BOARD, ID_LOW};

    reg_sel_e          sel;
    logic              wr_acc, rd_acc;
    logic [DATA_W-1:0] vflags, nvflags, tick_cnt, rd_mux;

    assign wr_acc = acc_stb &&  acc_we;
    assign rd_acc = acc_stb && !acc_we;

    sysreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (acc_addr),
        .sel  (sel)
    );

    sysreg_flagword #(.W(DATA_W)) u_vflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (soft_rst),
        .set_en  (wr_acc && sel == SEL_FSET),
        .clr_en  (wr_acc && sel == SEL_FCLR),
        .wdata   (acc_wdata),
        .q       (vflags)
    );

    sysreg_flagword #(.W(DATA_W)) u_nvflags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (1'b0),
        .set_en  (wr_acc && sel == SEL_NSET),
        .clr_en  (wr_acc && sel == SEL_NCLR),
        .wdata   (acc_wdata),
        .q       (nvflags)
    );

    sysreg_tick_ctr #(.W(DATA_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .q       (tick_cnt)
    );

    // stored control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_o        <= '0;
            flash_wp_n_o <= 1'b0;
            master_sel_o <= 1'b0;
        end else if (wr_acc) begin
            if (sel == SEL_LED)   led_o        <= acc_wdata[LED_N-1:0];
            if (sel == SEL_FLASH) flash_wp_n_o <= acc_wdata[0];
            if (sel == SEL_MISC)  master_sel_o <= acc_wdata[MASTER_BIT];
        end
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_ID:    rd_mux = DATA_W'(ID_WORD);
            SEL_SW:    rd_mux = DATA_W'(sw_i);
            SEL_LED:   rd_mux = DATA_W'(led_o);
            SEL_TICK:  rd_mux = tick_cnt;
            SEL_FSET:  rd_mux = vflags;
            SEL_NSET:  rd_mux = nvflags;
            SEL_CARD:  rd_mux = DATA_W'({card_wprot_i, card_present_i});
            SEL_FLASH: rd_mux = DATA_W'(flash_wp_n_o);
            SEL_MISC:  rd_mux[MASTER_BIT] = master_sel_o;
            SEL_PROC0: rd_mux = DATA_W'(PROC0_ID);
            SEL_PROC1: rd_mux = DATA_W'(PROC1_ID);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_rdata <= '0;
        else if (rd_acc) acc_rdata <= rd_mux;
    end

    // R12: read data moves only on a read access
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(acc_rdata));

    // R3: LED write shows on the pins one edge later
    p_led_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && acc_addr == ADDR_W'(OFS_LED)) |=> (led_o == $past(acc_wdata[LED_N-1:0])));

    // R9: flash protect changes only through its own write
    p_flash_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && acc_addr == ADDR_W'(OFS_FLASH)) |=> $stable(flash_wp_n_o));

    // R10: master select changes only through its own write
    p_master_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && acc_addr == ADDR_W'(OFS_MISC)) |=> $stable(master_sel_o));

endmodule

// File: tb/test_sysreg_bank.sv
`timescale 1ns/1ps
module test_sysreg_bank;

    localparam logic [31:0] ID_EXP  = 32'h0190_0A05;
    localparam logic [31:0] P0_EXP  = 32'h1400_0191;
    localparam logic [31:0] P1_EXP  = 32'h2400_0192;
    localparam int          NVEC    = 32;

    // fields: req[80:77] we[76] addr[75:64] wdata[63:32] expect[31:0]
    localparam logic [80:0] VEC [NVEC] = '{
        {4'd2,  1'b0, 12'h000, 32'h0,          ID_EXP},          // R2
        {4'd2,  1'b0, 12'h084, 32'h0,          P0_EXP},          // R2
        {4'd2,  1'b0, 12'h088, 32'h0,          P1_EXP},          // R2
        {4'd2,  1'b1, 12'h000, 32'hFFFF_FFFF,  32'h0},           // R2 ignored write
        {4'd2,  1'b1, 12'h084, 32'hFFFF_FFFF,  32'h0},           // R2 ignored write
        {4'd2,  1'b0, 12'h000, 32'h0,          ID_EXP},          // R2
        {4'd2,  1'b0, 12'h084, 32'h0,          P0_EXP},          // R2
        {4'd13, 1'b0, 12'h004, 32'h0,          32'h0000_00A5},   // R13
        {4'd3,  1'b1, 12'h008, 32'h0000_015A,  32'h0},           // R3
        {4'd3,  1'b0, 12'h008, 32'h0,          32'h0000_005A},   // R3
        {4'd4,  1'b1, 12'h030, 32'h0000_00F0,  32'h0},           // R4
        {4'd4,  1'b1, 12'h030, 32'h8000_0001,  32'h0},           // R4
        {4'd4,  1'b0, 12'h030, 32'h0,          32'h8000_00F1},   // R4
        {4'd5,  1'b1, 12'h034, 32'h0000_0030,  32'h0},           // R5
        {4'd5,  1'b0, 12'h030, 32'h0,          32'h8000_00C1},   // R5
        {4'd5,  1'b0, 12'h034, 32'h0,          32'h0},           // R5
        {4'd6,  1'b1, 12'h038, 32'h1234_0000,  32'h0},           // R6
        {4'd6,  1'b1, 12'h03C, 32'h0204_0000,  32'h0},           // R6
        {4'd6,  1'b0, 12'h038, 32'h0,          32'h1030_0000},   // R6
        {4'd6,  1'b0, 12'h030, 32'h0,          32'h8000_00C1},   // R6
        {4'd8,  1'b1, 12'h048, 32'hFFFF_FFFF,  32'h0},           // R8
        {4'd8,  1'b0, 12'h048, 32'h0,          32'h0000_0002},   // R8
        {4'd9,  1'b1, 12'h04C, 32'hFFFF_FFFF,  32'h0},           // R9
        {4'd9,  1'b0, 12'h04C, 32'h0,          32'h0000_0001},   // R9
        {4'd10, 1'b1, 12'h060, 32'hFFFF_FFFF,  32'h0},           // R10
        {4'd10, 1'b0, 12'h060, 32'h0,          32'h0000_4000},   // R10
        {4'd11, 1'b1, 12'h024, 32'hFFFF_FFFF,  32'h0},           // R11
        {4'd11, 1'b0, 12'h024, 32'h0,          32'h0},           // R11
        {4'd12, 1'b0, 12'h100, 32'h0,          32'h0},           // R12
        {4'd12, 1'b0, 12'h032, 32'h0,          32'h0},           // R12
        {4'd5,  1'b1, 12'h034, 32'hFFFF_FFFF,  32'h0},           // R5
        {4'd5,  1'b0, 12'h030, 32'h0,          32'h0}            // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        acc_stb = 1'b0;
    logic        acc_we = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        tick_en = 1'b0;
    logic [7:0]  sw_i = 8'hA5;
    logic        card_present_i = 1'b0;
    logic        card_wprot_i = 1'b1;
    logic [7:0]  led_o;
    logic        flash_wp_n_o;
    logic        master_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sysreg_bank #(
        .ID_BOARD (12'h190),
        .ID_LOW   (16'h0A05),
        .PROC0_ID (P0_EXP),
        .PROC1_ID (P1_EXP)
    ) i_sysreg_bank (
        .clk, .rst_n, .soft_rst, .acc_stb, .acc_we, .acc_addr, .acc_wdata,
        .acc_rdata, .tick_en, .sw_i, .card_present_i, .card_wprot_i,
        .led_o, .flash_wp_n_o, .master_sel_o
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus access; returns at the falling edge after the capturing edge
    task automatic access(logic we, logic [11:0] addr, logic [31:0] wd);
        @(negedge clk);
        acc_stb = 1'b1; acc_we = we; acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        acc_stb = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] addr, logic [31:0] exp);
        access(1'b0, addr, '0);
        chk(req, acc_rdata, exp);
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", acc_rdata, 32'h0);
        chk("R1", {24'h0, led_o}, 32'h0);
        chk("R1", {30'h0, flash_wp_n_o, master_sel_o}, 32'h0);
        rst_n = 1'b1;
        rd_chk("R1", 12'h030, 32'h0);
        rd_chk("R1", 12'h038, 32'h0);
        rd_chk("R1", 12'h024, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
            if (!VEC[i][76]) begin
                checks++;
                if (acc_rdata !== VEC[i][31:0]) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual %h expected %h",
                             VEC[i][80:77], i, acc_rdata, VEC[i][31:0]);
                end
            end
        end

        // R3 R9 R10: pin states after the table writes
        chk("R3", {24'h0, led_o}, 32'h5A);
        chk("R9", {31'h0, flash_wp_n_o}, 32'h1);
        chk("R10", {31'h0, master_sel_o}, 32'h1);

        // R8: inputs change, read follows
        card_present_i = 1'b1; card_wprot_i = 1'b0;
        rd_chk("R8", 12'h048, 32'h1);

        // R7: soft reset clears only the volatile flags
        access(1'b1, 12'h030, 32'h0000_0055);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd_chk("R7", 12'h030, 32'h0);
        rd_chk("R7", 12'h038, 32'h1030_0000);
        chk("R7", {24'h0, led_o}, 32'h5A);
        rd_chk("R7", 12'h04C, 32'h1);

        // R11: five ticks
        @(negedge clk); tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd_chk("R11", 12'h024, 32'h5);

        // R12: no strobe means no effect, and read data holds across a write
        held = acc_rdata;
        @(negedge clk);
        acc_we = 1'b1; acc_addr = 12'h008; acc_wdata = 32'h0;
        @(negedge clk);
        acc_we = 1'b0;
        chk("R12", {24'h0, led_o}, 32'h5A);
        access(1'b1, 12'h030, 32'h0000_0003);
        chk("R12", acc_rdata, held);

        // R1: power-on reset clears the non-volatile flags too
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1", {24'h0, led_o}, 32'h0);
        rd_chk("R1", 12'h038, 32'h0);
        rd_chk("R1", 12'h030, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule